// File: doc/BRIEF.md
# Indirect Register Window with PHY Management Readout

This unit is the host-facing register access path of a network controller. The host first loads an 8-bit address pointer through a pointer port. It then reads or writes the entry that the pointer selects through one of two data ports. One port reaches a control/status space and the other reaches a configuration space. Each space has 256 entries, and most of them behave as ordinary read/write words.

A few entries are special and are decoded here. The ring-size entry packs two log2 fields, and the unit drives the derived ring lengths out, clamped to 512 entries. A chip-identification entry returns a value that depends on the speed variant strap. One configuration entry reads a fixed constant. A PHY management data entry exposes a read-only view of a 32 by 32 array of 16-bit PHY registers. That view is addressed by a selector word held in a neighbouring configuration entry.

Entry 0 of the control space is the command word. Its storage and actions live outside this unit: reads return an external status input, and writes are forwarded as a strobe. All reads are registered, so data appears one cycle after the strobe.

Top module: `csr_window_unit`

## Requirements
- R1: `port_sel` encodes the target: 0 = pointer, 1 = control space, 2 = configuration space, 3 = unmapped. A write with `port_sel`=0 loads `wr_data[7:0]` into the pointer, and a read with `port_sel`=0 returns the pointer zero-extended. Nothing else changes the pointer.
- R2: After a cycle with `rd_en` high, `rd_valid` is high in the next cycle and `rd_data` then carries the selected value. `rd_valid` is low in every other cycle.
- R3: Control entry 6 holds the log2 receive ring size in bits 11:8 and the log2 transmit ring size in bits 15:12. A write updates both fields. A read returns them at the same positions, with all other bits 0.
- R4: `rx_ring_len` and `tx_ring_len` equal 2 raised to the stored log2 size, limited to 512 when the log2 value is 9 or more.
- R5: Control entry 88 reads 0x02623003 while `fast_variant` is 1 and 0 while it is 0. Writes to it have no effect.
- R6: Configuration entry 9 always reads 1. Writes to it have no effect.
- R7: Configuration entry 34 returns the reset default of the PHY register whose number sits in configuration entry 33 bits 4:0 (PHY address in bits 9:5), zero-extended. The defaults are: 0:0x1000, 1:0x782D, 2:0x2000, 3:0x5C01, 4:0x01E1, 22:0x0001, 23:0x8060, 24:0x8020, 25:0x0820, 27:0x3800, 28:0xA3B9, and 0 for every other register number, for every PHY address.
- R8: A write through configuration entry 34 does not modify any PHY register.
- R9: Every other entry of either space, including configuration entry 33, is a plain 32-bit read/write word. The two spaces are independent storage.
- R10: Control entry 0 reads `cmd_status`. A write to it drives `cmd_wr` high in the strobe cycle, with `cmd_wdata` equal to `wr_data`. No other access raises `cmd_wr`.
- R11: After reset the pointer, both log2 sizes and all plain storage are 0, the ring lengths are 1, and `rd_valid` is 0. Reads with `port_sel`=3 return 0, and writes with `port_sel`=3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Access target: pointer, control space, configuration space, unmapped |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| fast_variant | input | 1 | Speed variant strap that selects the chip identification value |
| cmd_status | input | 32 | External command/status word returned for control entry 0 |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the read strobe |
| cmd_wr | output | 1 | Write strobe for the external command word |
| cmd_wdata | output | 32 | Data for the external command word |
| rx_ring_len | output | 10 | Receive ring length derived from the log2 field |
| tx_ring_len | output | 10 | Transmit ring length derived from the log2 field |

## Verification
The assertions check several behaviours on every cycle. They cover the one-cycle read latency, pointer stability and readback, and the variant-dependent identification value. They also cover the constant configuration entry, the zero upper half of the PHY window, and the rule that ring lengths are a single power of two no larger than 512.

Some behaviours only the bench scenarios can show. Sweeps over all pointer values and over both spaces show that plain storage is independent. Every log2 ring value is checked, as is every PHY register number under several PHY addresses. Further scenarios show that writes to the identification, constant and PHY data entries leave the read values unchanged, and that the command strobe appears only for control entry 0.

// File: rtl/csr_window_pkg.sv
package csr_window_pkg;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    localparam int IDX_CMD      = 0;
    localparam int IDX_RING     = 6;
    localparam int IDX_CHIP_ID  = 88;
    localparam int IDX_CFG_ONE  = 9;
    localparam int IDX_MII_SEL  = 33;
    localparam int IDX_MII_DATA = 34;

    localparam logic [31:0] CHIP_ID_FAST = 32'h0262_3003;

    // Reset contents of a PHY register, identical for every PHY address.
    function automatic logic [15:0] phy_default(input logic [4:0] regno);
        case (regno)
            5'd0:    return 16'h1000;
            5'd1:    return 16'h782D;
            5'd2:    return 16'h2000;
            5'd3:    return 16'h5C01;
            5'd4:    return 16'h01E1;
            5'd22:   return 16'h0001;
            5'd23:   return 16'h8060;
            5'd24:   return 16'h8020;
            5'd25:   return 16'h0820;
            5'd27:   return 16'h3800;
            5'd28:   return 16'hA3B9;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/csr_word_bank.sv
module csr_word_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words_q[i] <= '0;
            end
        end else if (we) begin
            words_q[addr] <= wdata;
        end
    end

    assign rdata = words_q[addr];

endmodule

// File: rtl/ring_len_calc.sv
module ring_len_calc #(
    parameter int L2_W    = 4,
    parameter int MAX_LEN = 512,
    parameter int LEN_W   = $clog2(MAX_LEN) + 1
) (
    input  logic [L2_W-1:0]  l2_size,
    output logic [LEN_W-1:0] ring_len
);
    localparam int CLAMP_L2 = $clog2(MAX_LEN);

    always_comb begin
        if (int'(l2_size) >= CLAMP_L2) begin
            ring_len = LEN_W'(MAX_LEN);
        end else begin
            ring_len = LEN_W'(1) << l2_size;
        end
    end

endmodule

// File: rtl/csr_window_unit.sv
module csr_window_unit #(
    parameter int PTR_W    = 8,
    parameter int DATA_W   = 32,
    parameter int L2_W     = 4,
    parameter int RING_MAX = 512,
    localparam int LEN_W   = $clog2(RING_MAX) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        port_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fast_variant,
    input  logic [DATA_W-1:0] cmd_status,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              cmd_wr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic [LEN_W-1:0]  rx_ring_len,
    output logic [LEN_W-1:0]  tx_ring_len
);
    import csr_window_pkg::*;

    localparam int RX_LSB = 8;
    localparam int TX_LSB = RX_LSB + L2_W;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [L2_W-1:0]   rx_l2;
        logic [L2_W-1:0]   tx_l2;
        logic [DATA_W-1:0] mii_sel;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } state_t;

    state_t st_d, st_q;

    port_sel_e         sel;
    logic              hit_cmd, hit_ring, hit_id, hit_one, hit_msel, hit_mdat;
    logic              ctrl_we, cfg_we;
    logic [DATA_W-1:0] ctrl_rdata, cfg_rdata, rd_mux;

    assign sel = port_sel_e'(port_sel);

    assign hit_cmd  = (st_q.ptr == PTR_W'(IDX_CMD));
    assign hit_ring = (st_q.ptr == PTR_W'(IDX_RING));
    assign hit_id   = (st_q.ptr == PTR_W'(IDX_CHIP_ID));
    assign hit_one  = (st_q.ptr == PTR_W'(IDX_CFG_ONE));
    assign hit_msel = (st_q.ptr == PTR_W'(IDX_MII_SEL));
    assign hit_mdat = (st_q.ptr == PTR_W'(IDX_MII_DATA));

    assign ctrl_we = wr_en && (sel == SEL_CTRL) && !hit_cmd && !hit_ring && !hit_id;
    assign cfg_we  = wr_en && (sel == SEL_CFG) && !hit_one && !hit_msel && !hit_mdat;

    csr_word_bank #(.ADDR_W(PTR_W), .DATA_W(DATA_W)) i_ctrl_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .addr  (st_q.ptr),
        .wdata (wr_data),
        .rdata (ctrl_rdata)
    );

    csr_word_bank #(.ADDR_W(PTR_W), .DATA_W(DATA_W)) i_cfg_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (st_q.ptr),
        .wdata (wr_data),
        .rdata (cfg_rdata)
    );

    // Read multiplexer: special entries override the plain storage.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_PTR: rd_mux = DATA_W'(st_q.ptr);
            SEL_CTRL: begin
                if (hit_cmd)       rd_mux = cmd_status;
                else if (hit_ring) rd_mux = DATA_W'({st_q.tx_l2, st_q.rx_l2}) << RX_LSB;
                else if (hit_id)   rd_mux = fast_variant ? DATA_W'(CHIP_ID_FAST) : '0;
                else               rd_mux = ctrl_rdata;
            end
            SEL_CFG: begin
                if (hit_one)       rd_mux = DATA_W'(1);
                else if (hit_msel) rd_mux = st_q.mii_sel;
                else if (hit_mdat) rd_mux = DATA_W'(phy_default(st_q.mii_sel[4:0]));
                else               rd_mux = cfg_rdata;
            end
            default: rd_mux = '0;
        endcase
    end

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        st_d.rd_valid = rd_en;
        if (rd_en) begin
            st_d.rd_data = rd_mux;
        end
        if (wr_en) begin
            if (sel == SEL_PTR) begin
                st_d.ptr = wr_data[PTR_W-1:0];
            end
            if (sel == SEL_CTRL && hit_ring) begin
                st_d.rx_l2 = wr_data[RX_LSB +: L2_W];
                st_d.tx_l2 = wr_data[TX_LSB +: L2_W];
            end
            if (sel == SEL_CFG && hit_msel) begin
                st_d.mii_sel = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ring_len_calc #(.L2_W(L2_W), .MAX_LEN(RING_MAX), .LEN_W(LEN_W)) i_rx_len (
        .l2_size  (st_q.rx_l2),
        .ring_len (rx_ring_len)
    );

    ring_len_calc #(.L2_W(L2_W), .MAX_LEN(RING_MAX), .LEN_W(LEN_W)) i_tx_len (
        .l2_size  (st_q.tx_l2),
        .ring_len (tx_ring_len)
    );

    assign rd_data   = st_q.rd_data;
    assign rd_valid  = st_q.rd_valid;
    assign cmd_wr    = wr_en && (sel == SEL_CTRL) && hit_cmd;
    assign cmd_wdata = wr_data;

endmodule

// File: rtl/csr_window_checker.sv
module csr_window_checker #(
    parameter int PTR_W  = 8,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        port_sel,
    input logic              rd_en,
    input logic              wr_en,
    input logic              fast_variant,
    input logic [PTR_W-1:0]  ptr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [LEN_W-1:0]  rx_ring_len,
    input logic [LEN_W-1:0]  tx_ring_len
);
    import csr_window_pkg::*;

    assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_ptr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && port_sel == 2'd0) |=> $stable(ptr));

    assert_ptr_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && port_sel == 2'd0) |=> rd_data == DATA_W'($past(ptr)));

    assert_chip_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd1 && ptr == PTR_W'(IDX_CHIP_ID))
        |=> rd_data == ($past(fast_variant) ? DATA_W'(CHIP_ID_FAST) : '0));

    assert_cfg_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd2 && ptr == PTR_W'(IDX_CFG_ONE)) |=> rd_data == DATA_W'(1));

    assert_mii_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd2 && ptr == PTR_W'(IDX_MII_DATA)) |=> rd_data[DATA_W-1:16] == '0);

    assert_ring_len_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rx_ring_len) && $onehot(tx_ring_len)
        && rx_ring_len <= LEN_W'(512) && tx_ring_len <= LEN_W'(512));

endmodule

bind csr_window_unit csr_window_checker #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) i_csr_window_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_sel     (port_sel),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .fast_variant (fast_variant),
    .ptr          (st_q.ptr),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rx_ring_len  (rx_ring_len),
    .tx_ring_len  (tx_ring_len)
);

// File: tb/test_csr_window_unit.sv
module test_csr_window_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  port_sel = 2'd0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        fast_variant = 1'b0;
    logic [31:0] cmd_status = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        cmd_wr;
    logic [31:0] cmd_wdata;
    logic [9:0]  rx_ring_len, tx_ring_len;

    int n_cmp = 0;
    int n_bad = 0;
    logic        seen_cmd_wr;
    logic [31:0] seen_cmd_wdata;

    always #2 clk = ~clk;

    csr_window_unit i_csr_window_unit (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .fast_variant(fast_variant), .cmd_status(cmd_status),
        .rd_data(rd_data), .rd_valid(rd_valid), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .rx_ring_len(rx_ring_len), .tx_ring_len(tx_ring_len)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        port_sel = s; wr_en = 1'b1; wr_data = d;
        #1;
        seen_cmd_wr = cmd_wr;
        seen_cmd_wdata = cmd_wdata;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        port_sel = s; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R2 valid", {31'b0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    task automatic read_at(input logic [1:0] s, input int idx, output logic [31:0] d);
        do_write(2'd0, 32'(idx));
        do_read(s, d);
    endtask

    function automatic logic [15:0] exp_phy(input int r);
        case (r)
            0: return 16'h1000;   1: return 16'h782D;  2: return 16'h2000;
            3: return 16'h5C01;   4: return 16'h01E1;  22: return 16'h0001;
            23: return 16'h8060;  24: return 16'h8020; 25: return 16'h0820;
            27: return 16'h3800;  28: return 16'hA3B9;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [31:0] pat_ctrl(input int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
    endfunction

    function automatic logic [31:0] pat_cfg(input int i);
        return 32'h3C00_0000 ^ (32'(i) * 32'h0007_0905);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 valid low", {31'b0, rd_valid}, 32'd0);
        check("R11 rx len", 32'(rx_ring_len), 32'd1);
        check("R11 tx len", 32'(tx_ring_len), 32'd1);
        do_read(2'd0, v); check("R11 ptr", v, 32'd0);
        @(negedge clk);
        check("R2 valid drops", {31'b0, rd_valid}, 32'd0);
        read_at(2'd1, 6, v);  check("R11 ring reg", v, 32'd0);
        read_at(2'd1, 77, v); check("R11 ctrl storage", v, 32'd0);
        read_at(2'd2, 77, v); check("R11 cfg storage", v, 32'd0);

        // R1: pointer sweep
        for (int i = 0; i < 256; i++) begin
            do_write(2'd0, 32'hFFFF_FF00 | 32'(i));
            do_read(2'd0, v);
            check("R1 ptr readback", v, 32'(i));
        end

        // R11: unmapped target
        do_write(2'd0, 32'd45);
        do_write(2'd3, 32'h0000_0012);
        do_read(2'd3, v); check("R11 unmapped read", v, 32'd0);
        do_read(2'd0, v); check("R1 ptr after unmapped write", v, 32'd45);

        // R3, R4: every log2 value
        for (int r = 0; r < 16; r++) begin
            int t;
            t = 15 - r;
            do_write(2'd0, 32'd6);
            do_write(2'd1, 32'hFFFF_0000 | 32'(t << 12) | 32'(r << 8) | 32'h00FF);
            check("R4 rx len", 32'(rx_ring_len), (r >= 9) ? 32'd512 : (32'd1 << r));
            check("R4 tx len", 32'(tx_ring_len), (t >= 9) ? 32'd512 : (32'd1 << t));
            do_read(2'd1, v);
            check("R3 ring packing", v, 32'(t << 12) | 32'(r << 8));
        end

        // R5: chip identification, both variants, write ignored
        do_write(2'd0, 32'd88);
        do_write(2'd1, 32'hDEAD_BEEF);
        fast_variant = 1'b0;
        do_read(2'd1, v); check("R5 id slow", v, 32'd0);
        fast_variant = 1'b1;
        do_read(2'd1, v); check("R5 id fast", v, 32'h0262_3003);

        // R6: constant entry
        do_write(2'd0, 32'd9);
        do_write(2'd2, 32'h0000_FFFF);
        do_read(2'd2, v); check("R6 const", v, 32'd1);

        // R10: command word pass-through
        cmd_status = 32'h0000_1234;
        do_write(2'd0, 32'd0);
        do_read(2'd1, v); check("R10 status read", v, 32'h0000_1234);
        do_write(2'd1, 32'h0000_0042);
        check("R10 cmd strobe", {31'b0, seen_cmd_wr}, 32'd1);
        check("R10 cmd data", seen_cmd_wdata, 32'h0000_0042);
        do_write(2'd2, 32'h0000_0042);
        check("R10 no strobe cfg", {31'b0, seen_cmd_wr}, 32'd0);
        do_write(2'd0, 32'd5);
        do_write(2'd1, 32'h0000_0042);
        check("R10 no strobe other", {31'b0, seen_cmd_wr}, 32'd0);

        // R7: PHY window, all register numbers, several PHY addresses
        for (int p = 0; p < 32; p += 13) begin
            for (int r = 0; r < 32; r++) begin
                do_write(2'd0, 32'd33);
                do_write(2'd2, 32'(p << 5) | 32'(r));
                do_write(2'd0, 32'd34);
                do_read(2'd2, v);
                check("R7 phy default", v, 32'(exp_phy(r)));
            end
        end

        // R8: PHY writes ignored
        do_write(2'd0, 32'd33);
        do_write(2'd2, 32'd1);
        do_write(2'd0, 32'd34);
        do_write(2'd2, 32'h0000_BEEF);
        do_read(2'd2, v); check("R8 phy unchanged", v, 32'h0000_782D);

        // R9: plain storage in both spaces, all indices
        for (int i = 0; i < 256; i++) begin
            do_write(2'd0, 32'(i));
            if (i != 0 && i != 6 && i != 88) do_write(2'd1, pat_ctrl(i));
            if (i != 9 && i != 34)           do_write(2'd2, pat_cfg(i));
        end
        for (int i = 0; i < 256; i++) begin
            do_write(2'd0, 32'(i));
            if (i != 0 && i != 6 && i != 88) begin
                do_read(2'd1, v); check("R9 ctrl storage", v, pat_ctrl(i));
            end
            if (i != 9 && i != 34) begin
                do_read(2'd2, v); check("R9 cfg storage", v, pat_cfg(i));
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule